// File: doc/BRIEF.md
# Graphics Back-End Event Interrupt Register Block

This block tells a host CPU about two events from a graphics back-end: a token, which is a 16-bit marker the pipeline stores as it runs, and a finish, which marks the end of a frame's drawing. The host reaches the block through a 16-bit register bus that decodes the low 12 address bits. The pipeline side drives three strobes. The first stores a token value only. The second stores a token value and also requests an interrupt. The third signals finish. Each event has a pending flag and an enable bit. The block drives one level interrupt for each event, and each interrupt is high only while its flag and its enable are both set.

The host sets both enables and acknowledges pending events through one control word. The acknowledge bits in that word take effect when written and always read back as zero. The token register can be written only from the pipeline side. A host write to it changes nothing and raises a one-cycle error pulse. Five raster configuration words are held as plain read/write storage. Two separate clear inputs drop a pending flag and its interrupt, for use when the command stream is re-attached. A status output shows whether any event is still waiting to be serviced.

Top module: `gfx_event_regfile`

## Requirements
- R1: After synchronous reset, all stored words, enables and pending flags are zero. `host_rdata`, `irq_token`, `irq_finish`, `wait_status` and `host_wr_err` are all 0.
- R2: The configuration words sit at addresses 0x000, 0x002, 0x004, 0x006 and 0x008. Each holds all 16 bits written to it. A read returns data on `host_rdata` one clock after the cycle in which the read is requested, and `host_rdata` holds that value until the next read.
- R3: The control word is at 0x00A. Bit 0 is the token enable and bit 1 is the finish enable. Both read back as written. Bits 15:2 always read as 0.
- R4: A write to the control word loads both enables from bits 1:0. Writing 1 to bit 2 clears the token pending flag, and writing 1 to bit 3 clears the finish pending flag. Writing 0 to bit 2 or bit 3 leaves the matching flag unchanged.
- R5: `irq_token` equals the token pending flag AND the token enable. `irq_finish` equals the finish pending flag AND the finish enable. Both outputs reflect a change in the clock cycle right after the edge that caused it.
- R6: A `pipe_token_valid` strobe stores `pipe_token_value`. If `pipe_token_irq` is also high, the same strobe sets the token pending flag. If `pipe_token_irq` is low, the flag does not change.
- R7: A `pipe_finish` strobe sets the finish pending flag.
- R8: The token value reads at 0x00C. A 16-bit host write to 0x00C does not change the value, and `host_wr_err` is high for exactly the following cycle.
- R9: A read of any address other than the seven listed above returns 0x0001. A write to such an address has no effect. A write with `host_wide` high has no effect at any address.
- R10: `clr_token` clears the token pending flag and `clr_finish` clears the finish pending flag. Each clear overrides a same-cycle event or acknowledge.
- R11: If an event strobe and a host acknowledge of the same flag arrive in the same cycle, the flag is left set.
- R12: `wait_status` is high whenever either pending flag is set, whatever the enables are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_valid | input | 1 | Host access this cycle |
| host_write | input | 1 | 1 = write, 0 = read |
| host_wide | input | 1 | Access is a 32-bit write (ignored) |
| host_addr | input | 12 | Register address |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Registered read data |
| host_wr_err | output | 1 | Pulse: host tried to write the token register |
| pipe_token_valid | input | 1 | Pipeline token strobe |
| pipe_token_irq | input | 1 | Token strobe also requests an interrupt |
| pipe_token_value | input | 16 | Token value |
| pipe_finish | input | 1 | Pipeline finish strobe |
| clr_token | input | 1 | Clear token pending flag |
| clr_finish | input | 1 | Clear finish pending flag |
| irq_token | output | 1 | Token interrupt level |
| irq_finish | output | 1 | Finish interrupt level |
| wait_status | output | 1 | Some event is pending |

## Verification
A wrong pending flag shows on `wait_status` in the cycle after the strobe, acknowledge or clear that produced it. When the matching enable is set, it also shows on the interrupt line in that cycle. A wrong enable or a control bit that does not self-clear shows one cycle after the next read of the control word. A lost or corrupted token or configuration word shows in `host_rdata` one cycle after it is read. The reference model is therefore compared against every output on every clock. Stimulus reads back each word after every kind of disturbance, so a fault cannot stay hidden for more than a few cycles.

// File: rtl/gfx_evt_pkg.sv
package gfx_evt_pkg;

    localparam int ADDR_W  = 12;
    localparam int DATA_W  = 16;
    localparam int NUM_CFG = 5;
    localparam int CFG_IW  = $clog2(NUM_CFG);
    localparam int NUM_EVT = 2;

    localparam logic [ADDR_W-1:0] ADR_CFG_BASE = 12'h000;
    localparam logic [ADDR_W-1:0] ADR_CTRL     = 12'h00A;
    localparam logic [ADDR_W-1:0] ADR_TOKEN    = 12'h00C;
    localparam logic [DATA_W-1:0] UNMAPPED_RD  = 16'h0001;

    // Event channel order in the per-event arrays
    localparam int EVT_TOK = 0;
    localparam int EVT_FIN = 1;

    // Control word bit positions
    localparam int CB_EN_TOK  = 0;
    localparam int CB_EN_FIN  = 1;
    localparam int CB_ACK_TOK = 2;
    localparam int CB_ACK_FIN = 3;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_CFG,
        SEL_CTRL,
        SEL_TOKEN
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e            sel;
        logic [CFG_IW-1:0]   cfg_idx;
        logic                rd;
        logic                wr;
    } host_dec_t;

    typedef struct packed {
        logic [NUM_EVT-1:0] en;
        logic [NUM_EVT-1:0] ack;
    } ctrl_wr_t;

    function automatic logic cfg_hit(input logic [ADDR_W-1:0] a);
        return (a[0] == 1'b0) && (a >= ADR_CFG_BASE)
            && (a < ADR_CFG_BASE + 12'(2 * NUM_CFG));
    endfunction

    function automatic ctrl_wr_t split_ctrl(input logic [DATA_W-1:0] d);
        ctrl_wr_t c;
        c.en[EVT_TOK]  = d[CB_EN_TOK];
        c.en[EVT_FIN]  = d[CB_EN_FIN];
        c.ack[EVT_TOK] = d[CB_ACK_TOK];
        c.ack[EVT_FIN] = d[CB_ACK_FIN];
        return c;
    endfunction

endpackage

// File: rtl/gfx_host_decode.sv
module gfx_host_decode
    import gfx_evt_pkg::*;
(
    input  logic              valid,
    input  logic              write,
    input  logic              wide,
    input  logic [ADDR_W-1:0] addr,
    output host_dec_t         dec
);
    logic [ADDR_W-1:0] offs;

    always_comb begin
        offs        = addr - ADR_CFG_BASE;
        dec.rd      = valid && !write;
        dec.wr      = valid && write && !wide;
        dec.cfg_idx = '0;
        if (cfg_hit(addr)) begin
            dec.sel     = SEL_CFG;
            dec.cfg_idx = offs[CFG_IW:1];
        end else if (addr == ADR_CTRL) begin
            dec.sel = SEL_CTRL;
        end else if (addr == ADR_TOKEN) begin
            dec.sel = SEL_TOKEN;
        end else begin
            dec.sel = SEL_NONE;
        end
    end
endmodule

// File: rtl/gfx_cfg_bank.sv
module gfx_cfg_bank #(
    parameter int N  = 5,
    parameter int W  = 16,
    parameter int IW = $clog2(N)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                we,
    input  logic [IW-1:0]       idx,
    input  logic [W-1:0]        wdata,
    output logic [N-1:0][W-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst)
                q[i] <= '0;
            else if (we && (idx == IW'(i)))
                q[i] <= wdata;
        end
    end
endmodule

// File: rtl/gfx_evt_flag.sv
module gfx_evt_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic ack,
    input  logic clr,
    output logic pend
);
    // Priority: clear input, then event, then host acknowledge
    always_ff @(posedge clk) begin
        if (rst || clr)
            pend <= 1'b0;
        else if (set)
            pend <= 1'b1;
        else if (ack)
            pend <= 1'b0;
    end
endmodule

// File: rtl/gfx_event_regfile.sv
module gfx_event_regfile
    import gfx_evt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              host_valid,
    input  logic              host_write,
    input  logic              host_wide,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_wr_err,
    input  logic              pipe_token_valid,
    input  logic              pipe_token_irq,
    input  logic [DATA_W-1:0] pipe_token_value,
    input  logic              pipe_finish,
    input  logic              clr_token,
    input  logic              clr_finish,
    output logic              irq_token,
    output logic              irq_finish,
    output logic              wait_status
);
    host_dec_t                     dec;
    ctrl_wr_t                      cw;
    logic [NUM_CFG-1:0][DATA_W-1:0] cfg_q;
    logic [NUM_EVT-1:0]            en_q;
    logic [NUM_EVT-1:0]            pend;
    logic [NUM_EVT-1:0]            ev_set;
    logic [NUM_EVT-1:0]            ev_ack;
    logic [NUM_EVT-1:0]            ev_clr;
    logic [DATA_W-1:0]             token_q;
    logic [DATA_W-1:0]             rd_mux;
    logic                          ctrl_we;

    gfx_host_decode u_dec (
        .valid (host_valid),
        .write (host_write),
        .wide  (host_wide),
        .addr  (host_addr),
        .dec   (dec)
    );

    gfx_cfg_bank #(.N(NUM_CFG), .W(DATA_W)) u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (dec.wr && dec.sel == SEL_CFG),
        .idx   (dec.cfg_idx),
        .wdata (host_wdata),
        .q     (cfg_q)
    );

    assign cw      = split_ctrl(host_wdata);
    assign ctrl_we = dec.wr && (dec.sel == SEL_CTRL);

    always_ff @(posedge clk) begin
        if (rst)
            en_q <= '0;
        else if (ctrl_we)
            en_q <= cw.en;
    end

    always_ff @(posedge clk) begin
        if (rst)
            token_q <= '0;
        else if (pipe_token_valid)
            token_q <= pipe_token_value;
    end

    assign ev_set[EVT_TOK] = pipe_token_valid && pipe_token_irq;
    assign ev_set[EVT_FIN] = pipe_finish;
    assign ev_clr[EVT_TOK] = clr_token;
    assign ev_clr[EVT_FIN] = clr_finish;

    for (genvar e = 0; e < NUM_EVT; e++) begin : g_evt
        assign ev_ack[e] = ctrl_we && cw.ack[e];
        gfx_evt_flag u_flag (
            .clk  (clk),
            .rst  (rst),
            .set  (ev_set[e]),
            .ack  (ev_ack[e]),
            .clr  (ev_clr[e]),
            .pend (pend[e])
        );
    end

    assign irq_token   = pend[EVT_TOK] & en_q[EVT_TOK];
    assign irq_finish  = pend[EVT_FIN] & en_q[EVT_FIN];
    assign wait_status = |pend;

    always_comb begin
        unique case (dec.sel)
            SEL_CFG:   rd_mux = cfg_q[dec.cfg_idx];
            SEL_CTRL:  rd_mux = DATA_W'(en_q);
            SEL_TOKEN: rd_mux = token_q;
            default:   rd_mux = UNMAPPED_RD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            host_rdata  <= '0;
            host_wr_err <= 1'b0;
        end else begin
            if (dec.rd)
                host_rdata <= rd_mux;
            host_wr_err <= dec.wr && (dec.sel == SEL_TOKEN);
        end
    end
endmodule

// File: rtl/gfx_event_chk.sv
module gfx_event_chk
    import gfx_evt_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              host_valid,
    input logic              host_write,
    input logic              host_wide,
    input logic [ADDR_W-1:0] host_addr,
    input logic [DATA_W-1:0] host_wdata,
    input logic [DATA_W-1:0] host_rdata,
    input logic              host_wr_err,
    input logic              pipe_token_valid,
    input logic              pipe_token_irq,
    input logic [DATA_W-1:0] pipe_token_value,
    input logic              pipe_finish,
    input logic              clr_token,
    input logic              clr_finish,
    input logic              irq_token,
    input logic              irq_finish,
    input logic              wait_status
);
    // R12
    irq_implies_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_token || irq_finish) |-> wait_status);

    // R6
    token_evt_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (pipe_token_valid && pipe_token_irq && !clr_token) |=> wait_status);

    // R7
    finish_evt_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (pipe_finish && !clr_finish) |=> wait_status);

    // R10
    both_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_token && clr_finish) |=> (!wait_status && !irq_token && !irq_finish));

    // R8
    wr_err_cause_chk: assert property (@(posedge clk) disable iff (rst)
        host_wr_err |-> $past(host_valid && host_write && !host_wide
                              && host_addr == ADR_TOKEN));

    // R3
    ctrl_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (host_valid && !host_write && host_addr == ADR_CTRL)
        |=> (host_rdata[DATA_W-1:2] == '0));

    // R9
    unmapped_read_chk: assert property (@(posedge clk) disable iff (rst)
        (host_valid && !host_write && host_addr == 12'hFFE)
        |=> (host_rdata == UNMAPPED_RD));
endmodule

bind gfx_event_regfile gfx_event_chk u_chk (.*);

// File: tb/sim_gfx_event_regfile.sv
`timescale 1ns/1ps
module sim_gfx_event_regfile;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_valid = 0, host_write = 0, host_wide = 0;
    logic [11:0] host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        host_wr_err;
    logic        pipe_token_valid = 0, pipe_token_irq = 0;
    logic [15:0] pipe_token_value = '0;
    logic        pipe_finish = 0, clr_token = 0, clr_finish = 0;
    logic        irq_token, irq_finish, wait_status;

    always #5 clk = ~clk;

    gfx_event_regfile u0 (.*);

    int    n_chk = 0, n_fail = 0;
    string phase = "R1";
    bit    done = 0;

    // Behavioural reference model
    int unsigned m_cfg [5];
    bit          m_en_t, m_en_f, m_p_t, m_p_f, m_err;
    int unsigned m_tok, m_rd;

    function automatic int unsigned model_read(input int unsigned a);
        if (a <= 8 && a % 2 == 0) return m_cfg[a / 2];
        if (a == 'hA) return {m_en_f, m_en_t};
        if (a == 'hC) return m_tok;
        return 1;
    endfunction

    always @(posedge clk) begin
        bit ack_t, ack_f;
        if (rst) begin
            foreach (m_cfg[i]) m_cfg[i] = 0;
            m_en_t = 0; m_en_f = 0; m_p_t = 0; m_p_f = 0;
            m_tok = 0; m_rd = 0; m_err = 0;
        end else begin
            ack_t = 0; ack_f = 0;
            if (host_valid && !host_write) m_rd = model_read(host_addr);
            m_err = host_valid && host_write && !host_wide && host_addr == 12'h00C;
            if (host_valid && host_write && !host_wide) begin
                if (host_addr <= 8 && host_addr % 2 == 0) m_cfg[host_addr / 2] = host_wdata;
                else if (host_addr == 12'h00A) begin
                    m_en_t = host_wdata[0]; m_en_f = host_wdata[1];
                    ack_t = host_wdata[2];  ack_f = host_wdata[3];
                end
            end
            if (clr_token) m_p_t = 0;
            else if (pipe_token_valid && pipe_token_irq) m_p_t = 1;
            else if (ack_t) m_p_t = 0;
            if (clr_finish) m_p_f = 0;
            else if (pipe_finish) m_p_f = 1;
            else if (ack_f) m_p_f = 0;
            if (pipe_token_valid) m_tok = pipe_token_value;
        end
    end

    task automatic check(input string req, input int unsigned act, input int unsigned exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            check(phase, host_rdata, m_rd, "rdata");
            check(phase, host_wr_err, m_err, "wr_err");
            check(phase, irq_token, m_p_t & m_en_t, "irq_token");
            check(phase, irq_finish, m_p_f & m_en_f, "irq_finish");
            check(phase, wait_status, m_p_t | m_p_f, "wait_status");
        end
    end

    task automatic idle();
        host_valid = 0; host_write = 0; host_wide = 0;
        pipe_token_valid = 0; pipe_token_irq = 0; pipe_finish = 0;
        clr_token = 0; clr_finish = 0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [15:0] d);
        host_valid = 1; host_write = 1; host_addr = a; host_wdata = d;
        @(negedge clk); idle();
    endtask

    task automatic rd(input logic [11:0] a, input int unsigned exp, input string req);
        host_valid = 1; host_write = 0; host_addr = a;
        @(negedge clk); idle();
        check(req, host_rdata, exp, "directed read");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        check("R1", host_rdata, 0, "rdata after reset");
        check("R1", {irq_token, irq_finish, wait_status, host_wr_err}, 0, "flags after reset");
        rd(12'h00C, 0, "R1");
        rd(12'h00A, 0, "R1");

        phase = "R2";
        for (int i = 0; i < 5; i++) wr(12'(2 * i), 16'hA5C0 + 16'(i * 16'h1111));
        for (int i = 0; i < 5; i++) rd(12'(2 * i), 16'hA5C0 + 16'(i * 16'h1111), "R2");
        @(negedge clk);
        check("R2", host_rdata, 16'hA5C0 + 16'h4444, "rdata held");

        phase = "R3";
        wr(12'h00A, 16'hFFF3);
        rd(12'h00A, 16'h0003, "R3");
        wr(12'h00A, 16'h0001);
        rd(12'h00A, 16'h0001, "R3");

        phase = "R6";
        pipe_token_valid = 1; pipe_token_value = 16'h1234; @(negedge clk); idle();
        check("R6", wait_status, 0, "plain token no pending");
        rd(12'h00C, 16'h1234, "R6");
        pipe_token_valid = 1; pipe_token_irq = 1; pipe_token_value = 16'hBEEF; @(negedge clk); idle();
        check("R6", irq_token, 1, "token irq raised");
        rd(12'h00C, 16'hBEEF, "R6");

        phase = "R5";
        wr(12'h00A, 16'h0000);
        check("R5", irq_token, 0, "enable off masks irq");
        check("R12", wait_status, 1, "pending still visible");
        wr(12'h00A, 16'h0003);
        check("R5", irq_token, 1, "enable on restores irq");

        phase = "R7";
        pipe_finish = 1; @(negedge clk); idle();
        check("R7", irq_finish, 1, "finish irq");

        phase = "R4";
        wr(12'h00A, 16'h0007);
        check("R4", irq_token, 0, "token ack clears");
        check("R4", irq_finish, 1, "finish untouched");
        wr(12'h00A, 16'h000B);
        check("R4", irq_finish, 0, "finish ack clears");
        rd(12'h00A, 16'h0003, "R4");

        phase = "R11";
        pipe_token_valid = 1; pipe_token_irq = 1; pipe_token_value = 16'h0042;
        pipe_finish = 1;
        host_valid = 1; host_write = 1; host_addr = 12'h00A; host_wdata = 16'h000F;
        @(negedge clk); idle();
        check("R11", {irq_token, irq_finish}, 2'b11, "event beats ack");

        phase = "R10";
        clr_token = 1; @(negedge clk); idle();
        check("R10", irq_token, 0, "clr_token");
        check("R10", irq_finish, 1, "finish kept");
        clr_finish = 1; pipe_finish = 1; @(negedge clk); idle();
        check("R10", wait_status, 0, "clr beats event");

        phase = "R8";
        wr(12'h00C, 16'hDEAD);
        check("R8", host_wr_err, 1, "error pulse");
        @(negedge clk);
        check("R8", host_wr_err, 0, "error one cycle");
        rd(12'h00C, 16'h0042, "R8");

        phase = "R9";
        rd(12'hFFE, 16'h0001, "R9");
        rd(12'h100, 16'h0001, "R9");
        rd(12'h003, 16'h0001, "R9");
        wr(12'h100, 16'h5555);
        wr(12'h003, 16'h7777);
        rd(12'h002, 16'hB6D1, "R9");
        host_wide = 1; host_valid = 1; host_write = 1; host_addr = 12'h000; host_wdata = 16'h0000;
        @(negedge clk); idle();
        host_wide = 1; host_valid = 1; host_write = 1; host_addr = 12'h00A; host_wdata = 16'h0000;
        @(negedge clk); idle();
        rd(12'h000, 16'hA5C0, "R9");
        rd(12'h00A, 16'h0003, "R9");

        phase = "R12";
        wr(12'h00A, 16'h0000);
        pipe_finish = 1; @(negedge clk); idle();
        check("R12", wait_status, 1, "wait with enables off");
        check("R12", irq_finish, 0, "no irq when disabled");
        repeat (3) @(negedge clk);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule